// File: doc/BRIEF.md
# Fractional Slot-Mask Baud Generator

This block turns a fast reference clock into a one-clock sampling tick at sixteen times a serial bit rate, for the transmitter and receiver of a UART. Each bit period holds sixteen sub-bit intervals. Every interval lasts the integer divider setting plus one reference clocks. A sixteen-bit slot mask lengthens chosen intervals by one more clock, so the average bit period can be a non-integer number of reference clocks.

The fractional trim comes in one of two forms. In mask mode it is the sixteen-bit slot pattern itself. In value mode only its low four bits are used, as a remainder count from 0 to 15, and the block expands that count into an evenly spread mask. A second output strobes once per bit period, in the same cycle as the sixteenth tick. Settings are captured only at bit boundaries and during reset, so no period mixes old and new values.

Top module: `fractional_baud_gen`

## Requirements
- R1: Sub-bit interval k (k = 0..15, counted from 0 after each bit boundary or after reset) lasts `div_i + 1` enabled reference clocks, plus one more when bit k of the active mask is 1. `tick_o` is high for exactly the last clock of each interval.
- R2: `bit_end_o` is high only together with the sixteenth tick of a bit period, so exactly fifteen ticks separate two strobes.
- R3: One bit period lasts `16 * (div_i + 1) + (number of set mask bits)` enabled reference clocks.
- R4: With `trim_mode_i = 1` (value mode), the remainder is r = `trim_i[3:0]` and `trim_i[15:4]` is ignored. Mask bit k is 1 when `((k * r) mod 16) + r >= 16`, which sets exactly r bits.
- R5: With `trim_mode_i = 0` (mask mode), all sixteen bits of `trim_i` are used as the slot mask, bit k applying to interval k.
- R6: The divider, trim and mode inputs are captured while `rst_n` is low and in each cycle where `bit_end_o` is high. A change at any other time does not affect the period in progress.
- R7: While `en_i` is low, the interval count holds and `tick_o` and `bit_end_o` stay low. Counting resumes from where it stopped.
- R8: `rst_n` is a synchronous active-low reset. While it is low, `tick_o` and `bit_end_o` are low. It clears the interval count and the slot index, so the first interval after release is interval 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Reference clock |
| rst_n | input | 1 | Synchronous active-low reset |
| en_i | input | 1 | Counting enable |
| div_i | input | DIV_W | Integer divider; interval length minus one |
| trim_i | input | 16 | Slot mask (mask mode) or remainder in bits 3:0 (value mode) |
| trim_mode_i | input | 1 | 0 = mask mode, 1 = value mode |
| tick_o | output | 1 | One-clock sampling tick at 16x bit rate |
| bit_end_o | output | 1 | Bit-period boundary strobe, coincident with the 16th tick |

## Verification
A wrong interval count or a wrong slot index moves `tick_o` within the current interval. The cycle-by-cycle comparison therefore reports it at the first tick that lands early or late, which is at most `div_i + 2` clocks away. A bad remainder expansion or a bad mode choice keeps every interval legal, but the lengthened slots land in the wrong places. This shows at the first mismatching tick, and again when the bit period is measured at the next strobe. A configuration captured at the wrong moment changes the length of the period in progress, and the measurement catches it at the boundary that closes that period.

// File: rtl/fbg_pkg.sv
// Shared constants and types for the fractional baud generator.
// Assumes a power-of-two number of sub-bit slots per bit period.
package fbg_pkg;
    localparam int SLOT_COUNT = 16;
    localparam int IDX_W      = $clog2(SLOT_COUNT);

    typedef logic [SLOT_COUNT-1:0] slot_mask_t;

    typedef enum logic {
        TRIM_MASK  = 1'b0,
        TRIM_VALUE = 1'b1
    } trim_mode_e;
endpackage

// File: rtl/fbg_trim_decode.sv
// Turns the raw trim input into a slot mask. In mask mode the trim passes
// through unchanged. In value mode the low IDX_W bits form a remainder r,
// and slot k is set when the running phase (k*r mod SLOT_COUNT) wraps.
// Assumes: purely combinational, with the result registered downstream.
module fbg_trim_decode
    import fbg_pkg::*;
(
    input  logic       trim_mode_i,
    input  slot_mask_t trim_i,
    output slot_mask_t mask_o
);
    logic [IDX_W-1:0] rem;
    slot_mask_t       spread;

    assign rem = trim_i[IDX_W-1:0];

    for (genvar k = 0; k < SLOT_COUNT; k++) begin : g_slot
        // Purpose: phase wrap test for slot k.
        always_comb begin
            int phase;
            phase     = (k * int'(rem)) % SLOT_COUNT;
            spread[k] = (phase + int'(rem)) >= SLOT_COUNT;
        end
    end

    // Purpose: choose between the literal mask and the expanded remainder.
    always_comb begin
        if (trim_mode_e'(trim_mode_i) == TRIM_VALUE) mask_o = spread;
        else                                          mask_o = trim_i;
    end
endmodule

// File: rtl/fbg_cfg_shadow.sv
// Holds the divider and slot mask used by the running bit period.
// It loads while reset is low and on a load pulse (the bit boundary).
// Assumes the load pulse and the counter restart share the same edge.
module fbg_cfg_shadow
    import fbg_pkg::*;
#(
    parameter int DIV_W = 12
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             load_i,
    input  logic [DIV_W-1:0] div_i,
    input  slot_mask_t       mask_i,
    output logic [DIV_W-1:0] div_o,
    output slot_mask_t       mask_o
);
    // Purpose: capture new settings only at reset or at a boundary.
    always_ff @(posedge clk) begin
        if (!rst_n || load_i) begin
            div_o  <= div_i;
            mask_o <= mask_i;
        end
    end
endmodule

// File: rtl/fbg_tick_counter.sv
// Counts reference clocks for each sub-bit interval and walks the slot index.
// Interval k ends when the count reaches div + mask[k]. It then emits a tick
// and steps the index. The last slot also emits the boundary strobe.
// Assumes div and mask stay constant between boundaries.
module fbg_tick_counter
    import fbg_pkg::*;
#(
    parameter int DIV_W = 12
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             en_i,
    input  logic [DIV_W-1:0] div_i,
    input  slot_mask_t       mask_i,
    output logic             tick_o,
    output logic             bit_end_o
);
    localparam int CNT_W = DIV_W + 1;
    localparam logic [IDX_W-1:0] LAST_SLOT = IDX_W'(SLOT_COUNT - 1);

    logic [CNT_W-1:0] cnt;
    logic [CNT_W-1:0] limit;
    logic [IDX_W-1:0] slot;

    assign limit     = {1'b0, div_i} + CNT_W'(mask_i[slot]);
    assign tick_o    = rst_n & en_i & (cnt == limit);
    assign bit_end_o = tick_o & (slot == LAST_SLOT);

    // Purpose: advance the interval count and slot index.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            cnt  <= '0;
            slot <= '0;
        end else if (tick_o) begin
            cnt  <= '0;
            slot <= (slot == LAST_SLOT) ? '0 : slot + 1'b1;
        end else if (en_i) begin
            cnt <= cnt + 1'b1;
        end
    end
endmodule

// File: rtl/fractional_baud_gen.sv
// Top of the fractional baud generator. The trim is decoded into a slot mask,
// captured with the divider into shadow registers at each bit boundary, and
// used by the tick counter to lengthen selected sub-bit intervals.
// Assumes a single reference clock and a synchronous active-low reset.
module fractional_baud_gen
    import fbg_pkg::*;
#(
    parameter int DIV_W = 12
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             en_i,
    input  logic [DIV_W-1:0] div_i,
    input  logic [15:0]      trim_i,
    input  logic             trim_mode_i,
    output logic             tick_o,
    output logic             bit_end_o
);
    slot_mask_t       new_mask;
    slot_mask_t       act_mask;
    logic [DIV_W-1:0] act_div;

    fbg_trim_decode u_dec (
        .trim_mode_i (trim_mode_i),
        .trim_i      (trim_i),
        .mask_o      (new_mask)
    );

    fbg_cfg_shadow #(.DIV_W(DIV_W)) u_cfg (
        .clk    (clk),
        .rst_n  (rst_n),
        .load_i (bit_end_o),
        .div_i  (div_i),
        .mask_i (new_mask),
        .div_o  (act_div),
        .mask_o (act_mask)
    );

    fbg_tick_counter #(.DIV_W(DIV_W)) u_cnt (
        .clk       (clk),
        .rst_n     (rst_n),
        .en_i      (en_i),
        .div_i     (act_div),
        .mask_i    (act_mask),
        .tick_o    (tick_o),
        .bit_end_o (bit_end_o)
    );
endmodule

// File: rtl/fbg_checker.sv
// Property checker for the fractional baud generator. It keeps its own tick
// and gap counters and is bound into every instance of the top module.
module fbg_checker
    import fbg_pkg::*;
#(
    parameter int DIV_W = 12
) (
    input logic             clk,
    input logic             rst_n,
    input logic             en_i,
    input logic             tick_o,
    input logic             bit_end_o,
    input logic [DIV_W-1:0] act_div,
    input slot_mask_t       act_mask
);
    logic [DIV_W+1:0] gap;
    logic [IDX_W:0]   ticks_seen;

    // Purpose: enabled clocks since the previous tick.
    always_ff @(posedge clk) begin
        if (!rst_n || tick_o) gap <= '0;
        else if (en_i)        gap <= gap + 1'b1;
    end

    // Purpose: ticks since the previous boundary strobe.
    always_ff @(posedge clk) begin
        if (!rst_n || bit_end_o) ticks_seen <= '0;
        else if (tick_o)         ticks_seen <= ticks_seen + 1'b1;
    end

    // R1: each interval is div+1 or div+2 enabled clocks long
    assert_tick_gap_R1: assert property (@(posedge clk) disable iff (!rst_n)
        tick_o |-> (int'(gap) >= int'(act_div) && int'(gap) <= int'(act_div) + 1));

    // R2: the strobe comes only with a tick, after fifteen plain ticks
    assert_strobe_with_tick_R2: assert property (@(posedge clk) disable iff (!rst_n)
        bit_end_o |-> tick_o);
    assert_fifteen_before_R2: assert property (@(posedge clk) disable iff (!rst_n)
        bit_end_o |-> (int'(ticks_seen) == SLOT_COUNT - 1));

    // R6: active settings change only after a boundary
    assert_cfg_hold_R6: assert property (@(posedge clk) disable iff (!rst_n)
        !bit_end_o |=> ($stable(act_div) && $stable(act_mask)));

    // R7: no tick without enable
    assert_no_tick_idle_R7: assert property (@(posedge clk) disable iff (!rst_n)
        tick_o |-> en_i);

    // R8: outputs quiet during reset
    assert_quiet_reset_R8: assert property (@(posedge clk)
        !rst_n |-> (!tick_o && !bit_end_o));
endmodule

bind fractional_baud_gen fbg_checker #(.DIV_W(DIV_W)) u_fbg_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .en_i      (en_i),
    .tick_o    (tick_o),
    .bit_end_o (bit_end_o),
    .act_div   (act_div),
    .act_mask  (act_mask)
);

// File: tb/fractional_baud_gen_test.sv
module fractional_baud_gen_test;
    localparam int DW = 8;

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic          en_i = 1'b1;
    logic [DW-1:0] div_i = 8'd2;
    logic [15:0]   trim_i = 16'h0000;
    logic          trim_mode_i = 1'b0;
    logic          tick_o, bit_end_o;

    int checks = 0;
    int errs = 0;

    // behavioural model state
    int          m_cnt = 0, m_idx = 0, m_div = 2;
    logic [15:0] m_mask = '0;
    int          since_tick = 0, since_bnd = 0, last_period = 0, bnd_count = 0;

    always #4 clk = ~clk;

    fractional_baud_gen #(.DIV_W(DW)) uut (
        .clk(clk), .rst_n(rst_n), .en_i(en_i), .div_i(div_i),
        .trim_i(trim_i), .trim_mode_i(trim_mode_i),
        .tick_o(tick_o), .bit_end_o(bit_end_o)
    );

    function automatic logic [15:0] even_mask(input int r);
        int acc = 0;
        logic [15:0] m = '0;
        for (int k = 0; k < 16; k++) begin
            acc += r;
            if (acc >= 16) begin m[k] = 1'b1; acc -= 16; end
        end
        return m;
    endfunction

    task automatic chk(input bit ok, input string tag, input int act, input int exp);
        checks++;
        if (!ok) begin
            errs++;
            $display("FAIL %s actual=%0d expected=%0d at %0t", tag, act, exp, $time);
        end
    endtask

    task automatic latch_cfg();
        m_div  = int'(div_i);
        m_mask = trim_mode_i ? even_mask(int'(trim_i[3:0])) : trim_i;
    endtask

    // Model update on each rising edge.
    always @(posedge clk) begin
        if (!rst_n) begin
            m_cnt = 0; m_idx = 0; latch_cfg();
        end else if (en_i && m_cnt == m_div + int'(m_mask[m_idx])) begin
            m_cnt = 0;
            if (m_idx == 15) begin m_idx = 0; latch_cfg(); end
            else m_idx++;
        end else if (en_i) begin
            m_cnt++;
        end
    end

    // Compare on every clock, away from the active edge.
    always @(negedge clk) begin
        #1;
        if (!rst_n) begin
            chk(!tick_o && !bit_end_o, "R8 quiet in reset", int'(tick_o), 0);
            since_tick = 0; since_bnd = 0;
        end else begin
            bit exp_tick, exp_bnd;
            exp_tick = en_i && (m_cnt == m_div + int'(m_mask[m_idx]));
            exp_bnd  = exp_tick && (m_idx == 15);
            if (!en_i) chk(!tick_o, "R7 no tick when disabled", int'(tick_o), 0);
            chk(tick_o == exp_tick, "R1 tick", int'(tick_o), int'(exp_tick));
            chk(bit_end_o == exp_bnd, "R2 boundary", int'(bit_end_o), int'(exp_bnd));
            if (en_i) begin since_tick++; since_bnd++; end
            if (tick_o) begin
                chk(since_tick == m_div + 1 + int'(m_mask[m_idx]), "R1 interval",
                    since_tick, m_div + 1 + int'(m_mask[m_idx]));
                since_tick = 0;
            end
            if (bit_end_o) begin
                last_period = since_bnd;
                chk(since_bnd == 16 * (m_div + 1) + $countones(m_mask), "R3 period",
                    since_bnd, 16 * (m_div + 1) + $countones(m_mask));
                since_bnd = 0;
                bnd_count++;
            end
        end
    end

    task automatic wait_bnd(input int n);
        int b0 = bnd_count;
        wait (bnd_count >= b0 + n);
    endtask

    task automatic run_cfg(input int d, input logic [15:0] t, input logic mode, input int extra,
                           input string tag);
        @(negedge clk);
        div_i = DW'(d); trim_i = t; trim_mode_i = mode;
        wait_bnd(2);
        chk(last_period == 16 * (d + 1) + extra, tag, last_period, 16 * (d + 1) + extra);
    endtask

    initial begin
        repeat (4) @(negedge clk);
        rst_n = 1'b1;
        // R5 mask mode with even patterns and uneven ones
        run_cfg(2, 16'h0000, 1'b0, 0,  "R5 mask 0x0000");
        run_cfg(2, 16'h0080, 1'b0, 1,  "R5 mask 0x0080");
        run_cfg(2, 16'h0808, 1'b0, 2,  "R5 mask 0x0808");
        run_cfg(2, 16'h2222, 1'b0, 4,  "R5 mask 0x2222");
        run_cfg(2, 16'h5555, 1'b0, 8,  "R5 mask 0x5555");
        run_cfg(2, 16'hffdf, 1'b0, 15, "R5 mask 0xffdf");
        run_cfg(2, 16'h00f0, 1'b0, 4,  "R5 mask uses high bits");
        run_cfg(0, 16'hffff, 1'b0, 16, "R5 full mask div 0");
        // R4 value mode, every remainder
        for (int r = 0; r < 16; r++)
            run_cfg(2, 16'(r), 1'b1, r, "R4 value remainder");
        run_cfg(9, 16'hfff3, 1'b1, 3, "R4 upper trim bits ignored");
        run_cfg(0, 16'h0007, 1'b1, 7, "R4 value div 0");
        // R6 mid-period change applies only after the boundary
        run_cfg(3, 16'h0000, 1'b0, 0, "R6 setup");
        wait_bnd(1);
        repeat (10) @(negedge clk);
        div_i = DW'(5); trim_i = 16'h0005; trim_mode_i = 1'b1;
        wait_bnd(1);
        chk(last_period == 64, "R6 old settings kept", last_period, 64);
        wait_bnd(1);
        chk(last_period == 101, "R6 new settings applied", last_period, 101);
        // R7 enable pause mid-period
        wait_bnd(1);
        repeat (7) @(negedge clk);
        en_i = 1'b0;
        repeat (13) @(negedge clk);
        en_i = 1'b1;
        wait_bnd(1);
        chk(last_period == 101, "R7 pause does not shift count", last_period, 101);
        // R8 reset mid-period restarts at slot 0
        repeat (9) @(negedge clk);
        rst_n = 1'b0;
        div_i = DW'(1); trim_i = 16'h0001; trim_mode_i = 1'b0;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        wait_bnd(1);
        chk(last_period == 33, "R8 fresh period after reset", last_period, 33);
        repeat (5) @(negedge clk);
        $display("Result: errors=%0d of %0d checks", errs, checks);
        $finish;
    end

    initial begin
        #(8 * 200000);
        errs++; checks++;
        $display("FAIL watchdog actual=timeout expected=completion");
        $display("Result: errors=%0d of %0d checks", errs, checks);
        $finish;
    end
endmodule